// File: doc/BRIEF.md
# Quadrature Counter Channel with Byte-Serial Host Access

This block is a single 24-bit up/down position counter. It takes either a two-phase quadrature encoder (A/B, decoded at x1, x2 or x4 resolution) or a count/direction pair. The phase and index pins are each retimed through a two-flop synchroniser before any decoding.

A host reaches the channel over an 8-bit bus that has only two addresses.

- **Data address.** It carries the 24-bit preset register on writes and the 24-bit output latch on reads. Both move one byte at a time, least significant byte first, through a shared byte pointer.
- **Control address.** Writes carry command bytes. Reads return a status byte.

The counter is never written directly. The host fills the preset and then issues a transfer command. To read, the host snapshots the count into the output latch and reads the latch out.

Borrow and carry toggle flags flip on underflow and overflow. Their XOR serves the host as a 25th count bit. An error flag records illegal quadrature transitions. An optional index pulse can load the preset into the counter.

Top module: `qc_channel`

## Requirements
- R1: On a control write, bits 6:5 pick the target: 00 reset/load command, 01 counter mode, 10 I/O control, 11 index control. Bits 4:0 are the payload, so a mode write never acts as a command.
- R2: Each data-address access (read or write) moves the byte pointer forward. The pointer visits bytes 0, 1, 2 (LSB first) and wraps from 2 back to 0. Command payload bit 0 returns it to byte 0.
- R3: Command payload bit 3 copies the preset register into the counter. Data writes change only the preset, never the counter.
- R4: Command payload bit 4 copies the counter into the output latch. The latch then holds that value while the counter keeps moving.
- R5: Command payload bits 2:1 form a code: 01 clears the counter, 10 clears the borrow and carry toggles, 11 clears the error flag.
- R6: A control read returns the status byte. Bit 0 is the borrow toggle, bit 1 the carry toggle, bit 4 the error flag and bit 5 the last count direction (1 = up). All other bits read 0.
- R7: Counting up from 0xFFFFFF gives 0 and inverts the carry toggle. Counting down from 0 gives 0xFFFFFF and inverts the borrow toggle.
- R8: Counter mode bits 4:3 select the decoder.
  - 0: count/direction. Each rising edge of A counts, up when B is 1.
  - 1: x1.
  - 2: x2.
  - 3: x4.
  - The up phase order is AB = 00, 10, 11, 01. x4 counts every legal edge, x2 counts every edge of A, and x1 counts only edges of A while B is 0.
- R9: In a quadrature mode, a step in which A and B both change sets the error flag and does not count. The flag stays set until cleared.
- R10: With I/O control bit 0 at 0, the A/B inputs are ignored.
- R11: An index event loads the preset into the counter. This happens when index control bit 0 (enable) and I/O control bit 1 (preset-on-index) are both set. The event is the synchronised index entering its active level; index control bit 1 sets the active level (1 = high).
- R12: Reset clears the counter, preset, latch, pointer, mode registers and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 1 | 0 = data address, 1 = control address |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe (advances the pointer on the data address) |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Read byte: latch byte at the pointer, or the status byte |
| phaseA | input | 1 | Encoder phase A, or count clock |
| phaseB | input | 1 | Encoder phase B, or direction |
| indexIn | input | 1 | Index input |

## Verification
The hardest states to reach from the ports are the wrap points. The counter must be driven across zero in both directions. Going down from zero first raises the borrow toggle; going back up from 0xFFFFFF then raises the carry toggle, so both toggles are set together. The stimulus reaches this cheaply: it starts from the cleared counter and takes one reverse x4 step, then one forward step. After that it writes a fourth data byte to prove that the pointer wraps, and it moves the counter without re-latching to show that the latch holds its snapshot.

// File: rtl/qc_pkg.sv
package qc_pkg;
  // reset/load command strobes from control to datapath
  typedef struct packed {
    logic clrCount;
    logic loadPreset;
    logic clrToggles;
    logic clrError;
  } qcStrobe_t;

  typedef enum logic [1:0] {
    TGT_CMD  = 2'd0,
    TGT_MODE = 2'd1,
    TGT_IO   = 2'd2,
    TGT_IDX  = 2'd3
  } qcTarget_e;

  typedef enum logic [1:0] {
    SCALE_CNTDIR = 2'd0,
    SCALE_X1     = 2'd1,
    SCALE_X2     = 2'd2,
    SCALE_X4     = 2'd3
  } qcScale_e;
endpackage

// File: rtl/qc_ctrl.sv
module qc_ctrl
  import qc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              borrowT,
  input  logic              carryT,
  input  logic              errFlag,
  input  logic              dirUp,
  output qcStrobe_t         strb,
  output logic [CNT_W-1:0]  preset,
  output logic [4:0]        modeReg,
  output logic [4:0]        ioReg,
  output logic [4:0]        idxReg
);
  localparam int BYTES = CNT_W / BYTE_W;
  localparam int PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(BYTES - 1);

  logic [PTR_W-1:0] bytePtr;
  logic [CNT_W-1:0] outLatch;
  qcTarget_e        target;
  logic [4:0]       payload;
  logic             ctlWr, cmdWr, dataAcc, latchStrobe;

  assign target      = qcTarget_e'(busWdata[6:5]);
  assign payload     = busWdata[4:0];
  assign ctlWr       = busWr && busAddr;
  assign cmdWr       = ctlWr && (target == TGT_CMD);
  assign dataAcc     = !busAddr && (busWr || busRd);
  assign latchStrobe = cmdWr && payload[4];

  always_comb begin
    strb.clrCount   = cmdWr && (payload[2:1] == 2'b01);
    strb.clrToggles = cmdWr && (payload[2:1] == 2'b10);
    strb.clrError   = cmdWr && (payload[2:1] == 2'b11);
    strb.loadPreset = cmdWr && payload[3];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytePtr  <= '0;
      preset   <= '0;
      outLatch <= '0;
      modeReg  <= '0;
      ioReg    <= '0;
      idxReg   <= '0;
    end else begin
      if (dataAcc) begin
        bytePtr <= (bytePtr == PTR_LAST) ? '0 : bytePtr + 1'b1;
        if (busWr) begin
          for (int i = 0; i < BYTES; i++)
            if (bytePtr == PTR_W'(i)) preset[i*BYTE_W +: BYTE_W] <= busWdata;
        end
      end
      if (cmdWr && payload[0]) bytePtr <= '0;
      if (latchStrobe) outLatch <= count;
      if (ctlWr && target == TGT_MODE) modeReg <= payload;
      if (ctlWr && target == TGT_IO)   ioReg   <= payload;
      if (ctlWr && target == TGT_IDX)  idxReg  <= payload;
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr) begin
      busRdata[0] = borrowT;
      busRdata[1] = carryT;
      busRdata[4] = errFlag;
      busRdata[5] = dirUp;
    end else begin
      for (int i = 0; i < BYTES; i++)
        if (bytePtr == PTR_W'(i)) busRdata = outLatch[i*BYTE_W +: BYTE_W];
    end
  end

  // R4: the snapshot only moves on a latch command
  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !latchStrobe |=> $stable(outLatch));
  // R2: pointer stays within the byte range
  a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    dataAcc |=> bytePtr <= PTR_LAST);
endmodule

// File: rtl/qc_datapath.sv
module qc_datapath
  import qc_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  qcStrobe_t        strb,
  input  logic [CNT_W-1:0] preset,
  input  logic [1:0]       scaleSel,
  input  logic             enAB,
  input  logic             idxLoadEn,
  input  logic             idxEn,
  input  logic             idxPol,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic             indexIn,
  output logic [CNT_W-1:0] count,
  output logic             borrowT,
  output logic             carryT,
  output logic             errFlag,
  output logic             dirUp
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] syncStage [SYNC_STAGES];
  logic [2:0] nowIn, prevIn;
  logic aNow, bNow, iNow, aChg, bChg, iPrev;
  logic step, up, illegal, idxEvent, anyCmd;
  qcScale_e scale;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncStage[i] <= '0;
      prevIn <= '0;
    end else begin
      syncStage[0] <= {indexIn, phaseB, phaseA};
      for (int i = 1; i < SYNC_STAGES; i++) syncStage[i] <= syncStage[i-1];
      prevIn <= nowIn;
    end
  end

  assign nowIn = syncStage[SYNC_STAGES-1];
  assign aNow  = nowIn[0];
  assign bNow  = nowIn[1];
  assign iNow  = nowIn[2];
  assign iPrev = prevIn[2];
  assign aChg  = aNow ^ prevIn[0];
  assign bChg  = bNow ^ prevIn[1];
  assign scale = qcScale_e'(scaleSel);

  always_comb begin
    step = 1'b0;
    up   = 1'b0;
    unique case (scale)
      SCALE_CNTDIR: begin step = aChg && aNow;          up = bNow; end
      SCALE_X1:     begin step = aChg && !bChg && !bNow; up = aNow; end
      SCALE_X2:     begin step = aChg && !bChg;          up = aNow ^ bNow; end
      SCALE_X4:     begin step = aChg ^ bChg;
                          up = aChg ? (aNow ^ bNow) : !(aNow ^ bNow); end
      default: ;
    endcase
    step    = step && enAB;
    illegal = enAB && (scale != SCALE_CNTDIR) && aChg && bChg;
  end

  assign idxEvent = idxEn && idxLoadEn && (iNow == idxPol) && (iPrev != idxPol);
  assign anyCmd   = strb.clrCount || strb.loadPreset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      borrowT <= 1'b0;
      carryT  <= 1'b0;
      errFlag <= 1'b0;
      dirUp   <= 1'b0;
    end else begin
      if (strb.clrCount)        count <= '0;
      else if (strb.loadPreset) count <= preset;
      else if (idxEvent)        count <= preset;
      else if (step) begin
        dirUp <= up;
        if (up) begin
          count <= count + 1'b1;
          if (count == CNT_MAX) carryT <= !carryT;
        end else begin
          count <= count - 1'b1;
          if (count == '0) borrowT <= !borrowT;
        end
      end
      if (strb.clrToggles) begin
        borrowT <= 1'b0;
        carryT  <= 1'b0;
      end
      if (strb.clrError)  errFlag <= 1'b0;
      else if (illegal)   errFlag <= 1'b1;
    end
  end

  // R7: overflow inverts carry
  a_r7_carry_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (step && up && count == CNT_MAX && !anyCmd && !idxEvent && !strb.clrToggles)
      |=> (count == '0) && (carryT != $past(carryT)));
  // R7: underflow inverts borrow
  a_r7_borrow_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (step && !up && count == '0 && !anyCmd && !idxEvent && !strb.clrToggles)
      |=> (count == CNT_MAX) && (borrowT != $past(borrowT)));
  // R9: error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !strb.clrError |=> errFlag);
  // R3: transfer command lands the preset
  a_r3_preset_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadPreset && !strb.clrCount |=> count == $past(preset));
  // R10: disabled inputs leave the count alone
  a_r10_gate: assert property (@(posedge clk) disable iff (!rstN)
    !enAB && !idxEvent && !anyCmd |=> $stable(count));
endmodule

// File: rtl/qc_channel.sv
module qc_channel
  import qc_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic              indexIn
);
  qcStrobe_t        strb;
  logic [CNT_W-1:0] count, preset;
  logic [4:0]       modeReg, ioReg, idxReg;
  logic             borrowT, carryT, errFlag, dirUp;

  qc_ctrl #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .count(count),
    .borrowT(borrowT), .carryT(carryT), .errFlag(errFlag), .dirUp(dirUp),
    .strb(strb), .preset(preset), .modeReg(modeReg), .ioReg(ioReg), .idxReg(idxReg)
  );

  qc_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .preset(preset),
    .scaleSel(modeReg[4:3]), .enAB(ioReg[0]), .idxLoadEn(ioReg[1]),
    .idxEn(idxReg[0]), .idxPol(idxReg[1]),
    .phaseA(phaseA), .phaseB(phaseB), .indexIn(indexIn),
    .count(count), .borrowT(borrowT), .carryT(carryT),
    .errFlag(errFlag), .dirUp(dirUp)
  );
endmodule

// File: tb/sim_qc_channel.sv
module sim_qc_channel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic phaseA = 1'b0, phaseB = 1'b0, indexIn = 1'b0;
  int checks = 0, failures = 0, cycles = 0;

  always #4 clk = !clk;  // 125 MHz

  qc_channel u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .phaseA(phaseA), .phaseB(phaseB), .indexIn(indexIn));

  // {A, B, expected dir, expected count} for x4 stepping from 0 (R8)
  localparam logic [26:0] VEC [8] = '{
    {2'b10, 1'b1, 24'd1}, {2'b11, 1'b1, 24'd2}, {2'b01, 1'b1, 24'd3},
    {2'b00, 1'b1, 24'd4}, {2'b01, 1'b0, 24'd3}, {2'b11, 1'b0, 24'd2},
    {2'b10, 1'b0, 24'd1}, {2'b00, 1'b0, 24'd0}};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1; #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic readLatch(output logic [23:0] v);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin rd(1'b0, b); v[i*8 +: 8] = b; end
  endtask

  task automatic readCount(output logic [23:0] v);
    wr(1'b1, 8'h11);
    readLatch(v);
  endtask

  task automatic setAB(input logic a, input logic b);
    @(negedge clk); phaseA = a; phaseB = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic setIdx(input logic v);
    @(negedge clk); indexIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    logic [23:0] v;
    logic [7:0] s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rd(1'b1, s); check("R12 status after reset", s, 8'h00);
    readCount(v); check("R12 count after reset", v, 0);

    // x4 vector walk (R8, R6 direction bit)
    wr(1'b1, 8'h38); wr(1'b1, 8'h41);
    for (int i = 0; i < 8; i++) begin
      setAB(VEC[i][26], VEC[i][25]);
      readCount(v); check("R8 x4 count", v, VEC[i][23:0]);
      rd(1'b1, s); check("R6 dir bit", s, {2'b00, VEC[i][24], 5'b0});
    end

    // wraps (R7)
    setAB(1'b0, 1'b1);
    readCount(v); check("R7 underflow count", v, 24'hFFFFFF);
    rd(1'b1, s); check("R7 borrow toggle", s, 8'h01);
    setAB(1'b0, 1'b0);
    readCount(v); check("R7 overflow count", v, 0);
    rd(1'b1, s); check("R7 carry toggle", s, 8'h23);
    wr(1'b1, 8'h04);
    rd(1'b1, s); check("R5 clear toggles", s, 8'h20);

    // illegal transition (R9)
    setAB(1'b1, 1'b1);
    rd(1'b1, s); check("R9 error set", s, 8'h30);
    readCount(v); check("R9 no count on illegal", v, 0);
    wr(1'b1, 8'h06);
    rd(1'b1, s); check("R5 clear error", s, 8'h20);

    // preset path and pointer (R2, R3)
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h56); wr(1'b0, 8'h34); wr(1'b0, 8'h12);
    readCount(v); check("R3 data write leaves counter", v, 0);
    wr(1'b1, 8'h08);
    readCount(v); check("R3 preset transfer", v, 24'h123456);
    wr(1'b0, 8'hAA);
    wr(1'b1, 8'h08);
    readCount(v); check("R2 pointer wrap to byte0", v, 24'h1234AA);

    // latch holds snapshot (R4)
    setAB(1'b0, 1'b1);
    wr(1'b1, 8'h01);
    readLatch(v); check("R4 latch holds", v, 24'h1234AA);
    readCount(v); check("R4 new snapshot", v, 24'h1234AB);
    wr(1'b1, 8'h02);
    readCount(v); check("R5 clear counter", v, 0);

    // inputs disabled (R10, R1)
    wr(1'b1, 8'h40);
    setAB(1'b0, 1'b0); setAB(1'b1, 1'b0);
    readCount(v); check("R10 disabled inputs", v, 0);
    setAB(1'b0, 1'b0);

    // count/direction mode (R8)
    wr(1'b1, 8'h20); wr(1'b1, 8'h41);
    setAB(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin setAB(1'b1, 1'b1); setAB(1'b0, 1'b1); end
    setAB(1'b0, 1'b0); setAB(1'b1, 1'b0); setAB(1'b0, 1'b0);
    readCount(v); check("R8 count/dir mode", v, 2);

    // x2 (R8)
    wr(1'b1, 8'h30); wr(1'b1, 8'h02);
    setAB(1'b1, 1'b0); setAB(1'b1, 1'b1); setAB(1'b0, 1'b1); setAB(1'b0, 1'b0);
    readCount(v); check("R8 x2 cycle", v, 2);

    // x1 (R8)
    wr(1'b1, 8'h28); wr(1'b1, 8'h02);
    setAB(1'b1, 1'b0); setAB(1'b1, 1'b1); setAB(1'b0, 1'b1); setAB(1'b0, 1'b0);
    readCount(v); check("R8 x1 up cycle", v, 1);
    setAB(1'b0, 1'b1); setAB(1'b1, 1'b1); setAB(1'b1, 1'b0); setAB(1'b0, 1'b0);
    readCount(v); check("R8 x1 down cycle", v, 0);
    setAB(1'b1, 1'b0); setAB(1'b1, 1'b1); setAB(1'b0, 1'b1); setAB(1'b0, 1'b0);

    // mode write with command-like payload is not a command (R1)
    wr(1'b1, 8'h22);
    readCount(v); check("R1 mode target not command", v, 1);

    // index load (R11)
    wr(1'b1, 8'h43); wr(1'b1, 8'h63);
    setIdx(1'b1);
    readCount(v); check("R11 index high load", v, 24'h1234AA);
    setIdx(1'b0);
    wr(1'b1, 8'h02); wr(1'b1, 8'h61);
    setIdx(1'b1);
    readCount(v); check("R11 inactive edge ignored", v, 0);
    setIdx(1'b0);
    readCount(v); check("R11 index low load", v, 24'h1234AA);

    // reset mid-run (R12)
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(1'b1, s); check("R12 status cleared", s, 8'h00);
    readCount(v); check("R12 count cleared", v, 0);
    finish();
  end
endmodule